// File: doc/BRIEF.md
# Sequence Alignment Cell ALU

This block scores a single entry of the dynamic-programming matrix used to compare two DNA sequences. Each operation takes the scores of the three neighbouring entries (west, north and the diagonal northwest one) and the 2-bit nucleotide codes of the current row and column. It forms three weighted candidates and returns the smallest one as an 8-bit score, which gives edit-distance semantics. A 2-bit code beside the score tells which path won.

The costs are not fixed in logic. Four 8-bit weight registers hold the insertion, deletion, match and mismatch costs, and a small address/data/write-enable port rewrites them at run time. This lets the same cell be used with a different scoring scheme without changing the logic.

Cells on the same anti-diagonal do not depend on each other. The block therefore accepts a fresh, independent operand set on every clock and carries no state from one operation to the next. Operands are captured on an input-valid strobe, and the result appears with its own valid flag one clock after capture.

Top module: `align_cell_alu`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears out_valid, out_score and out_dir to zero. It loads the weights insertion=1, deletion=1, match=0 and mismatch=1.
- R2: Nucleotide codes are 2 bits (A=00, C=01, G=10, T=11). The diagonal candidate is diag_score plus the match weight when base_row equals base_col, and diag_score plus the mismatch weight when they differ.
- R3: The north candidate is north_score plus the deletion weight. The west candidate is west_score plus the insertion weight.
- R4: out_score is the minimum of the three candidates.
- R5: Every candidate addition saturates at 255 and never wraps.
- R6: out_dir reports the winning path: 00 diagonal, 01 north, 10 west. On equal candidates the diagonal wins over north, and north wins over west. The code 11 never appears.
- R7: A rising edge with cfg_we high writes cfg_wdata to the weight at cfg_addr (0 insertion, 1 deletion, 2 match, 3 mismatch). The new value applies to operations scored at later edges. An operation scored at the write edge uses the old value.
- R8: Operands are captured at an edge where in_valid is high. out_valid is high in exactly the cycle after such a capture edge, and out_score and out_dir carry that operation's result in that cycle.
- R9: Operand sets offered on consecutive cycles are scored independently, one result per cycle, with no influence between them.
- R10: After an edge where in_valid is low, the next result leaves out_score and out_dir unchanged and drops out_valid, even if the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Weight write enable |
| cfg_addr | input | 2 | Weight select: 0 insertion, 1 deletion, 2 match, 3 mismatch |
| cfg_wdata | input | 8 | Weight write value |
| in_valid | input | 1 | Operand set valid; captures the operands |
| west_score | input | 8 | West neighbour score |
| north_score | input | 8 | North neighbour score |
| diag_score | input | 8 | Northwest neighbour score |
| base_row | input | 2 | Nucleotide code of the row sequence |
| base_col | input | 2 | Nucleotide code of the column sequence |
| out_valid | output | 1 | Result valid |
| out_score | output | 8 | Minimum weighted candidate |
| out_dir | output | 2 | Winning path: 00 diagonal, 01 north, 10 west |

## Verification
All sixteen pairs of nucleotide codes are applied with the other paths held high. This isolates the match and mismatch choice on the diagonal path. Directed sets then make each path the unique minimum, force two-way and three-way ties to expose the priority order, and push the sums past 255 so that wrapping can be told apart from saturation. Weight rewrites, long runs of random operands on consecutive cycles, and idle gaps with changing inputs separate weights taking effect late, leakage between operations and unwanted updates while idle.

// File: rtl/align_pkg.sv
package align_pkg;
    parameter int SCORE_W = 8;
    parameter int BASE_W  = 2;
    parameter int NUM_WT  = 4;
    parameter int NUM_CAND = 3;
    localparam int WADDR_W = $clog2(NUM_WT);

    typedef logic [SCORE_W-1:0] score_t;
    typedef logic [BASE_W-1:0]  base_t;

    // weight register addresses
    localparam logic [WADDR_W-1:0] WA_INS = 2'd0;
    localparam logic [WADDR_W-1:0] WA_DEL = 2'd1;
    localparam logic [WADDR_W-1:0] WA_MAT = 2'd2;
    localparam logic [WADDR_W-1:0] WA_MIS = 2'd3;

    typedef enum logic [1:0] {
        DIR_DIAG  = 2'b00,
        DIR_NORTH = 2'b01,
        DIR_WEST  = 2'b10
    } dir_e;

    typedef struct packed {
        score_t ins;
        score_t del;
        score_t mat;
        score_t mis;
    } weights_t;

    typedef struct packed {
        logic   vld;
        score_t west;
        score_t north;
        score_t diag;
        base_t  row;
        base_t  col;
    } opnd_t;

    typedef struct packed {
        logic   vld;
        score_t score;
        dir_e   dir;
    } rslt_t;
endpackage

// File: rtl/align_weight_regs.sv
module align_weight_regs
    import align_pkg::*;
#(
    parameter score_t RST_INS = 8'd1,
    parameter score_t RST_DEL = 8'd1,
    parameter score_t RST_MAT = 8'd0,
    parameter score_t RST_MIS = 8'd1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  score_t             wr_data,
    output weights_t           weights
);
    weights_t wt_d, wt_q;

    always_comb begin
        wt_d = wt_q;
        if (wr_en) begin
            case (wr_addr)
                WA_INS:  wt_d.ins = wr_data;
                WA_DEL:  wt_d.del = wr_data;
                WA_MAT:  wt_d.mat = wr_data;
                default: wt_d.mis = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wt_q <= '{ins: RST_INS, del: RST_DEL, mat: RST_MAT, mis: RST_MIS};
        end else begin
            wt_q <= wt_d;
        end
    end

    assign weights = wt_q;

    AST_WEIGHT_INS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == WA_INS) |=> (weights.ins == $past(wr_data)))
        else $error("insertion weight write lost"); // R7
    AST_WEIGHT_MIS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> $stable(weights.mis))
        else $error("mismatch weight changed without write"); // R7
endmodule

// File: rtl/align_sat_add.sv
module align_sat_add
    import align_pkg::*;
(
    input  score_t base,
    input  score_t cost,
    output score_t sum
);
    localparam int EXT_W = SCORE_W + 1;
    logic [EXT_W-1:0] wide;

    always_comb begin
        wide = {1'b0, base} + {1'b0, cost};
        if (wide[SCORE_W]) begin
            sum = '1;
        end else begin
            sum = wide[SCORE_W-1:0];
        end
    end

    always_comb begin
        if (!$isunknown({base, cost})) begin
            AST_NO_OVERFLOW: assert (sum >= base && sum >= cost)
                else $error("candidate sum wrapped"); // R5
        end
    end
endmodule

// File: rtl/align_min3_select.sv
module align_min3_select
    import align_pkg::*;
(
    input  score_t cand [NUM_CAND],
    output score_t best,
    output dir_e   dir
);
    // candidate order is the tie priority: 0 diag, 1 north, 2 west
    always_comb begin
        if (cand[0] <= cand[1] && cand[0] <= cand[2]) begin
            best = cand[0];
            dir  = DIR_DIAG;
        end else if (cand[1] <= cand[2]) begin
            best = cand[1];
            dir  = DIR_NORTH;
        end else begin
            best = cand[2];
            dir  = DIR_WEST;
        end
    end

    always_comb begin
        if (!$isunknown({cand[0], cand[1], cand[2]})) begin
            AST_BEST_IS_MIN: assert (best <= cand[0] && best <= cand[1] && best <= cand[2])
                else $error("selected score is not the minimum"); // R4
            AST_DIR_LEGAL: assert (dir != 2'b11)
                else $error("illegal direction code"); // R6
        end
    end
endmodule

// File: rtl/align_cell_alu.sv
module align_cell_alu
    import align_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [7:0]          cfg_wdata,
    input  logic                in_valid,
    input  logic [7:0]          west_score,
    input  logic [7:0]          north_score,
    input  logic [7:0]          diag_score,
    input  logic [1:0]          base_row,
    input  logic [1:0]          base_col,
    output logic                out_valid,
    output logic [7:0]          out_score,
    output logic [1:0]          out_dir
);
    weights_t wts;
    opnd_t    opnd_d, opnd_q;
    rslt_t    rslt_d, rslt_q;
    score_t   cand_base [NUM_CAND];
    score_t   cand_cost [NUM_CAND];
    score_t   cand_sum  [NUM_CAND];
    score_t   best;
    dir_e     best_dir;

    align_weight_regs u_wregs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .weights (wts)
    );

    // candidate operands: 0 diagonal, 1 north, 2 west
    always_comb begin
        cand_base[0] = opnd_q.diag;
        cand_cost[0] = (opnd_q.row == opnd_q.col) ? wts.mat : wts.mis;
        cand_base[1] = opnd_q.north;
        cand_cost[1] = wts.del;
        cand_base[2] = opnd_q.west;
        cand_cost[2] = wts.ins;
    end

    for (genvar gi = 0; gi < NUM_CAND; gi++) begin : g_cand
        align_sat_add u_add (
            .base (cand_base[gi]),
            .cost (cand_cost[gi]),
            .sum  (cand_sum[gi])
        );
    end

    align_min3_select u_sel (
        .cand (cand_sum),
        .best (best),
        .dir  (best_dir)
    );

    always_comb begin
        opnd_d     = opnd_q;
        opnd_d.vld = in_valid;
        if (in_valid) begin
            opnd_d.west  = west_score;
            opnd_d.north = north_score;
            opnd_d.diag  = diag_score;
            opnd_d.row   = base_row;
            opnd_d.col   = base_col;
        end
        rslt_d     = rslt_q;
        rslt_d.vld = opnd_q.vld;
        if (opnd_q.vld) begin
            rslt_d.score = best;
            rslt_d.dir   = best_dir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
            rslt_q <= '{vld: 1'b0, score: '0, dir: DIR_DIAG};
        end else begin
            opnd_q <= opnd_d;
            rslt_q <= rslt_d;
        end
    end

    assign out_valid = rslt_q.vld;
    assign out_score = rslt_q.score;
    assign out_dir   = rslt_q.dir;

    AST_VALID_FOLLOWS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(opnd_q.vld))
        else $error("out_valid does not follow the captured operand"); // R8
    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (rst)
        !$past(opnd_q.vld) |-> ($stable(out_score) && $stable(out_dir)))
        else $error("result changed without an operation"); // R10
    AST_OUT_DIR_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_dir != 2'b11))
        else $error("illegal direction on output"); // R6
endmodule

// File: tb/align_cell_alu_tb.sv
module align_cell_alu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       in_valid = 1'b0;
    logic [7:0] west_score = '0, north_score = '0, diag_score = '0;
    logic [1:0] base_row = '0, base_col = '0;
    logic       out_valid;
    logic [7:0] out_score;
    logic [1:0] out_dir;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    comparing = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_w [4];
    int m_opv, m_ow, m_on, m_od, m_or, m_oc;
    int m_outv, m_score, m_dir;

    always #5 clk = ~clk;

    align_cell_alu u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .west_score(west_score), .north_score(north_score),
        .diag_score(diag_score), .base_row(base_row), .base_col(base_col),
        .out_valid(out_valid), .out_score(out_score), .out_dir(out_dir)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_w[0] = 1; m_w[1] = 1; m_w[2] = 0; m_w[3] = 1;
            m_opv = 0; m_outv = 0; m_score = 0; m_dir = 0;
            m_ow = 0; m_on = 0; m_od = 0; m_or = 0; m_oc = 0;
        end else begin
            int cd, cn, cw;
            m_outv = m_opv;
            if (m_opv != 0) begin
                cd = m_od + ((m_or == m_oc) ? m_w[2] : m_w[3]);
                cn = m_on + m_w[1];
                cw = m_ow + m_w[0];
                if (cd > 255) cd = 255;
                if (cn > 255) cn = 255;
                if (cw > 255) cw = 255;
                if (cd <= cn && cd <= cw) begin m_score = cd; m_dir = 0; end
                else if (cn <= cw) begin m_score = cn; m_dir = 1; end
                else begin m_score = cw; m_dir = 2; end
            end
            if (in_valid) begin
                m_ow = west_score; m_on = north_score; m_od = diag_score;
                m_or = base_row; m_oc = base_col;
            end
            m_opv = in_valid ? 1 : 0;
            if (cfg_we) m_w[cfg_addr] = cfg_wdata;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (comparing && !done) begin
            check(cur_req, int'(out_valid), m_outv, "out_valid");
            check(cur_req, int'(out_score), m_score, "out_score");
            check(cur_req, int'(out_dir), m_dir, "out_dir");
        end
    end

    task automatic op(input int w, input int n, input int d, input int r, input int c);
        @(negedge clk);
        in_valid = 1'b1;
        west_score = w[7:0]; north_score = n[7:0]; diag_score = d[7:0];
        base_row = r[1:0]; base_col = c[1:0];
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            cfg_we = 1'b0;
            west_score = 8'($urandom); north_score = 8'($urandom); diag_score = 8'($urandom);
            base_row = 2'($urandom); base_col = 2'($urandom);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = a[1:0]; cfg_wdata = v[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        check("R1", int'(out_valid), 0, "out_valid in reset");
        check("R1", int'(out_score), 0, "out_score in reset");
        check("R1", int'(out_dir), 0, "out_dir in reset");
        rst = 1'b0;
        comparing = 1'b1;

        // R1: default weights seen through results (match 0, deletion 1, insertion 1)
        cur_req = "R1";
        op(20, 20, 10, 1, 1);
        op(20, 7, 30, 0, 3);
        op(4, 20, 30, 0, 3);
        idle(3);

        // R2: all code pairs, diagonal isolated
        cur_req = "R2";
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                op(200, 200, 50, r, c);
        idle(2);

        // R3: north and west winning alone
        cur_req = "R3";
        op(100, 3, 90, 2, 1);
        op(2, 100, 90, 2, 1);
        op(0, 0, 255, 0, 1);
        idle(2);

        // R6: ties
        cur_req = "R6";
        op(9, 4, 5, 3, 3);
        op(4, 4, 9, 3, 3);
        op(4, 4, 5, 1, 1);
        op(7, 7, 9, 0, 2);
        idle(2);

        // R7: weight rewrite, scored right at the write edge and after
        cur_req = "R7";
        op(50, 50, 50, 1, 2);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'd40;
        @(negedge clk);
        cfg_we = 1'b0;
        wr(0, 3); wr(1, 9); wr(2, 5);
        op(50, 50, 50, 1, 2);
        op(50, 50, 50, 2, 2);
        op(50, 45, 60, 2, 2);
        idle(2);

        // R5: saturation
        cur_req = "R5";
        wr(0, 200); wr(1, 200); wr(2, 100); wr(3, 200);
        op(200, 200, 200, 0, 1);
        op(250, 50, 250, 0, 1);
        op(255, 255, 200, 3, 3);
        op(100, 255, 255, 1, 2);
        idle(2);

        // R4 and R9: random back-to-back operands with random weights
        cur_req = "R4";
        for (int k = 0; k < 8; k++) begin
            wr(k % 4, $urandom_range(0, 255));
            for (int j = 0; j < 40; j++)
                op($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
                   $urandom_range(0, 3), $urandom_range(0, 3));
        end
        cur_req = "R9";
        wr(0, 1); wr(1, 2); wr(2, 0); wr(3, 3);
        for (int j = 0; j < 60; j++)
            op($urandom_range(0, 40), $urandom_range(0, 40), $urandom_range(0, 40),
               $urandom_range(0, 3), $urandom_range(0, 3));

        // R8 and R10: sparse strobes with changing idle inputs
        cur_req = "R8";
        for (int j = 0; j < 30; j++) begin
            op($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
               $urandom_range(0, 3), $urandom_range(0, 3));
            cur_req = "R10";
            idle($urandom_range(1, 3));
            cur_req = "R8";
        end
        idle(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule